// File: doc/BRIEF.md
# Cipher Key Registers and Crypt Mode Control

This block sits next to the register file of a pipelined processor and holds the three 64-bit keys that a triple block cipher in the fetch and memory stages consumes, plus the flag that switches encrypted execution on or off. The writeback stage writes it. A key-load instruction delivers one 32-bit word together with a key index and a half selector. The lower and upper halves of each key come from two separate instructions. A mode instruction carries a single argument: any nonzero value turns crypt mode on, and zero turns it off.

The cipher cores need a stable key before they use it, so the block also drives a readiness flag. After any accepted key write, the flag stays low for two cycles. Software is expected to place two empty slots between its last key load and the mode instruction. The flag lets the surrounding pipeline, or an assertion, confirm that this spacing was kept. Keys and mode then stay as written until they are reloaded or the block is reset.

Top module: `cipher_key_mode_regs`

## Requirements
- R1: The block holds three keys of 64 bits. Key k appears on `keys_flat` bits [64k+63:64k].
- R2: A key write with `wb_key_half` = 0 loads `wb_key_data` into bits 31:0 of the key chosen by `wb_key_idx`. The new value is visible one cycle after the write, and bits 63:32 of that key are unchanged.
- R3: A key write with `wb_key_half` = 1 loads `wb_key_data` into bits 63:32 of the chosen key. Bits 31:0 are unchanged, and the value is visible the next cycle.
- R4: A mode write sets `crypt_en` to 1 from the next cycle when `wb_mode_arg` is nonzero (any bit set), and to 0 when it is zero.
- R5: In a cycle with no write, all keys and `crypt_en` keep their values.
- R6: During and after reset, all keys read zero, `crypt_en` is 0 and `keys_ready` is 1.
- R7: After an accepted key write, `keys_ready` is 0 in the two cycles that follow the write edge. It is 1 from the third cycle on, unless a later key write restarts the wait.
- R8: A key write with `wb_key_idx` = 3 (no such key) changes no key and does not disturb `keys_ready`.
- R9: A key write and a mode write in the same cycle are both applied. The mode change shows on the next cycle, and `keys_ready` still drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_key_we | input | 1 | Key word write strobe from writeback |
| wb_key_half | input | 1 | 0 = lower word, 1 = upper word |
| wb_key_idx | input | 2 | Key index, 0 to 2 valid |
| wb_key_data | input | 32 | Key word to write |
| wb_mode_we | input | 1 | Mode instruction strobe |
| wb_mode_arg | input | 26 | Mode argument, nonzero enables |
| keys_flat | output | 192 | All three keys, key 0 in the low bits |
| crypt_en | output | 1 | Crypt mode flag |
| keys_ready | output | 1 | High once the key settle wait has passed |

## Verification
The hardest case to reach is a key write that lands while the settle wait from an earlier write is still running. Two outcomes must be told apart there: the wait restarting, and the wait finishing on its old schedule. The stimulus issues back-to-back and one-gap key loads, writes to the missing fourth index in the middle of a wait, and mixes these with mode writes in the same cycle. A long random phase then keeps producing such overlaps, and a cycle model compares every output on every clock.

// File: rtl/ckm_pkg.sv
package ckm_pkg;
   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } ckm_half_e;

   function automatic int ckm_idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/ckm_key_bank.sv
module ckm_key_bank #(
   parameter int WORD_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lo_we,
   input  logic                hi_we,
   input  logic [WORD_W-1:0]   wdata,
   output logic [2*WORD_W-1:0] key
);
   logic [WORD_W-1:0] lo_q;
   logic [WORD_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (lo_we) lo_q <= wdata;
         if (hi_we) hi_q <= wdata;
      end
   end

   assign key = {hi_q, lo_q};
endmodule

// File: rtl/ckm_mode_reg.sv
module ckm_mode_reg #(
   parameter int ARG_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [ARG_W-1:0] arg,
   output logic             crypt_en
);
   logic mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  mode_q <= 1'b0;
      else if (we) mode_q <= |arg;
   end

   assign crypt_en = mode_q;
endmodule

// File: rtl/ckm_settle_timer.sv
module ckm_settle_timer #(
   parameter int SETTLE_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic ready
);
   generate
      if (SETTLE_CYCLES == 0) begin : g_none
         assign ready = 1'b1;
      end else begin : g_count
         localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
         localparam logic [CNT_W-1:0] DONE = CNT_W'(SETTLE_CYCLES);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)              cnt_q <= DONE;
            else if (restart)        cnt_q <= '0;
            else if (cnt_q != DONE)  cnt_q <= cnt_q + 1'b1;
         end

         assign ready = (cnt_q == DONE);
      end
   endgenerate
endmodule

// File: rtl/cipher_key_mode_regs.sv
module cipher_key_mode_regs #(
   parameter int NUM_KEYS      = 3,
   parameter int WORD_W        = 32,
   parameter int KEY_W         = 64,
   parameter int ARG_W         = 26,
   parameter int SETTLE_CYCLES = 2,
   parameter int IDX_W         = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wb_key_we,
   input  logic                      wb_key_half,
   input  logic [IDX_W-1:0]          wb_key_idx,
   input  logic [WORD_W-1:0]         wb_key_data,
   input  logic                      wb_mode_we,
   input  logic [ARG_W-1:0]          wb_mode_arg,
   output logic [NUM_KEYS*KEY_W-1:0] keys_flat,
   output logic                      crypt_en,
   output logic                      keys_ready
);
   import ckm_pkg::*;

   localparam logic [IDX_W:0] KEY_LIMIT = (IDX_W+1)'(NUM_KEYS);

   initial begin
      if (KEY_W != 2 * WORD_W)
         $fatal(1, "KEY_W must be twice WORD_W");
      if (IDX_W < ckm_idx_width(NUM_KEYS))
         $fatal(1, "IDX_W too narrow for NUM_KEYS");
      if (NUM_KEYS < 1)
         $fatal(1, "NUM_KEYS must be at least one");
   end

   ckm_half_e half;
   logic      write_ok;

   assign half     = ckm_half_e'(wb_key_half);
   assign write_ok = wb_key_we && ({1'b0, wb_key_idx} < KEY_LIMIT);

   genvar k;
   generate
      for (k = 0; k < NUM_KEYS; k++) begin : g_key
         logic hit;
         assign hit = write_ok && (wb_key_idx == IDX_W'(k));

         ckm_key_bank #(.WORD_W(WORD_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .lo_we (hit && (half == HALF_LO)),
            .hi_we (hit && (half == HALF_HI)),
            .wdata (wb_key_data),
            .key   (keys_flat[k*KEY_W +: KEY_W])
         );
      end
   endgenerate

   ckm_mode_reg #(.ARG_W(ARG_W)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (wb_mode_we),
      .arg      (wb_mode_arg),
      .crypt_en (crypt_en)
   );

   ckm_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (write_ok),
      .ready   (keys_ready)
   );
endmodule

// File: rtl/ckm_checker.sv
module ckm_checker #(
   parameter int NUM_KEYS      = 3,
   parameter int WORD_W        = 32,
   parameter int KEY_W         = 64,
   parameter int ARG_W         = 26,
   parameter int SETTLE_CYCLES = 2,
   parameter int IDX_W         = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wb_key_we,
   input logic                      wb_key_half,
   input logic [IDX_W-1:0]          wb_key_idx,
   input logic [WORD_W-1:0]         wb_key_data,
   input logic                      wb_mode_we,
   input logic [ARG_W-1:0]          wb_mode_arg,
   input logic [NUM_KEYS*KEY_W-1:0] keys_flat,
   input logic                      crypt_en,
   input logic                      keys_ready
);
   logic valid_wr;
   assign valid_wr = wb_key_we && (int'(wb_key_idx) < NUM_KEYS);

   AST_LOW_WORD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_wr && !wb_key_half) |=> keys_flat[int'($past(wb_key_idx))*KEY_W +: WORD_W] == $past(wb_key_data)); // R2
   AST_HIGH_WORD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_wr && wb_key_half) |=> keys_flat[int'($past(wb_key_idx))*KEY_W + WORD_W +: WORD_W] == $past(wb_key_data)); // R3
   AST_MODE_FOLLOWS_ARG: assert property (@(posedge clk) disable iff (!rst_n)
      wb_mode_we |=> crypt_en == ($past(wb_mode_arg) != '0)); // R4
   AST_KEYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_wr |=> $stable(keys_flat)); // R5
   AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_mode_we |=> $stable(crypt_en)); // R5
   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      valid_wr |=> !keys_ready); // R7
   AST_READY_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      valid_wr |=> ##1 !keys_ready); // R7
   AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_key_we && !valid_wr && keys_ready) |=> keys_ready); // R8
endmodule

bind cipher_key_mode_regs ckm_checker #(
   .NUM_KEYS(NUM_KEYS), .WORD_W(WORD_W), .KEY_W(KEY_W),
   .ARG_W(ARG_W), .SETTLE_CYCLES(SETTLE_CYCLES), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/sim_cipher_key_mode_regs.sv
`timescale 1ns/1ps
module sim_cipher_key_mode_regs;
   localparam int NK = 3;
   localparam int KW = 64;
   localparam int WW = 32;
   localparam int AW = 26;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            wb_key_we = 1'b0;
   logic            wb_key_half = 1'b0;
   logic [1:0]      wb_key_idx = '0;
   logic [WW-1:0]   wb_key_data = '0;
   logic            wb_mode_we = 1'b0;
   logic [AW-1:0]   wb_mode_arg = '0;
   logic [NK*KW-1:0] keys_flat;
   logic            crypt_en;
   logic            keys_ready;

   cipher_key_mode_regs u0 (.*);

   logic [KW-1:0] m_key [NK];
   logic          m_mode;
   int            m_wait;
   int            tests = 0;
   int            fails = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [KW-1:0] act, input logic [KW-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      for (int k = 0; k < NK; k++)
         chk(keys_flat[k*KW +: KW] === m_key[k], tag, $sformatf("key%0d (R1)", k),
             keys_flat[k*KW +: KW], m_key[k]);
      chk(crypt_en === m_mode, tag, "crypt_en (R4)", 64'(crypt_en), 64'(m_mode));
      chk(keys_ready === (m_wait >= 2), tag, "keys_ready (R7)",
          64'(keys_ready), 64'(m_wait >= 2));
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic cycle(input bit kwe, input bit hi, input logic [1:0] idx,
                        input logic [WW-1:0] d, input bit mwe,
                        input logic [AW-1:0] arg, input string tag);
      wb_key_we = kwe; wb_key_half = hi; wb_key_idx = idx; wb_key_data = d;
      wb_mode_we = mwe; wb_mode_arg = arg;
      @(posedge clk);
      if (kwe && idx < 2'd3) begin
         if (hi) m_key[idx][63:32] = d;
         else    m_key[idx][31:0]  = d;
         m_wait = 0;
      end else if (m_wait < 2) begin
         m_wait++;
      end
      if (mwe) m_mode = (arg != '0);
      @(negedge clk);
      wb_key_we = 1'b0; wb_mode_we = 1'b0;
      compare_all(tag);
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      for (int k = 0; k < NK; k++) m_key[k] = '0;
      m_mode = 1'b0;
      m_wait = 2;
      repeat (3) @(negedge clk);
      compare_all("R6 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R6 after reset");

      // R2 / R3: build keys word by word
      cycle(1, 0, 2'd0, 32'h1111_2222, 0, '0, "R2 key0 low");
      cycle(1, 1, 2'd0, 32'hAAAA_BBBB, 0, '0, "R3 key0 high");
      cycle(1, 1, 2'd2, 32'h4B49_5241, 0, '0, "R3 key2 high");
      cycle(1, 0, 2'd2, 32'h5450_414C, 0, '0, "R2 key2 low");
      cycle(1, 0, 2'd1, 32'hDEAD_BEEF, 0, '0, "R2 key1 low");
      // R7: two empty slots before ready
      cycle(0, 0, 2'd0, '0, 0, '0, "R7 slot1");
      cycle(0, 0, 2'd0, '0, 0, '0, "R7 slot2");
      cycle(0, 0, 2'd0, '0, 1, 26'd1, "R4 enable");
      cycle(0, 0, 2'd0, '0, 0, '0, "R5 idle");
      cycle(0, 0, 2'd0, '0, 0, '0, "R5 idle");
      // R8: missing index while ready, then inside a wait
      cycle(1, 0, 2'd3, 32'hFFFF_FFFF, 0, '0, "R8 idx3 low");
      cycle(1, 1, 2'd3, 32'h0BAD_0BAD, 0, '0, "R8 idx3 high");
      cycle(1, 1, 2'd1, 32'h0123_4567, 0, '0, "R3 key1 high");
      cycle(1, 0, 2'd3, 32'h7777_7777, 0, '0, "R8 idx3 during wait");
      cycle(0, 0, 2'd0, '0, 0, '0, "R7 finish");
      // R4: zero disables, high bit alone enables
      cycle(0, 0, 2'd0, '0, 1, '0, "R4 disable");
      cycle(0, 0, 2'd0, '0, 1, 26'h200_0000, "R4 top bit");
      // R9: key and mode in one cycle
      cycle(1, 0, 2'd0, 32'hCAFE_F00D, 1, '0, "R9 both");
      cycle(1, 1, 2'd2, 32'h0000_0001, 1, 26'h3, "R9 both again");
      cycle(1, 0, 2'd1, 32'h5555_AAAA, 0, '0, "R7 back to back");
      cycle(0, 0, 2'd0, '0, 0, '0, "R7 gap");
      cycle(1, 1, 2'd0, 32'h9999_0000, 0, '0, "R7 restart after gap");
      cycle(0, 0, 2'd0, '0, 0, '0, "R5 idle");
      cycle(0, 0, 2'd0, '0, 0, '0, "R5 idle");

      for (int i = 0; i < 400; i++) begin
         bit kwe = ($urandom_range(0, 2) == 0);
         bit mwe = ($urandom_range(0, 4) == 0);
         bit hi  = 1'($urandom);
         logic [1:0] idx = 2'($urandom);
         logic [AW-1:0] arg = ($urandom_range(0, 1) == 0) ? '0 : AW'($urandom);
         cycle(kwe, hi, idx, $urandom, mwe, arg, "R9 random mix");
      end

      // reset again in mid-state
      rst_n = 1'b0;
      @(negedge clk);
      for (int k = 0; k < NK; k++) m_key[k] = '0;
      m_mode = 1'b0;
      m_wait = 2;
      compare_all("R6 second reset");
      rst_n = 1'b1;

      summary();
      $finish;
   end
endmodule